// File: doc/BRIEF.md
# Three-Port Latched Bus Exchanger

This block joins a processor-side port A to two memory-side ports, B1 and B2, each `W` bits wide (12 by default). Traffic from A toward the memory side passes through two independent latching paths, one per B port. This lets a single processor word be posted to either bank or to both, as memory interleaving needs. Traffic toward the processor passes through two further latching paths, one from each B port. A route select decides which of these two reaches A, which gives address or data multiplexing from two banks.

Each of the four paths is transparent while its open input is high: the path input appears on the path output in the same cycle. When the open input is low, the path output presents the value it held at the last rising clock edge at which the path was open. Each port has an active-low output enable. The bidirectional pins are split into an input vector, an output vector and an active-high drive flag, so a pad wrapper can build the tri-state buffers. A synchronous active-high reset clears all four held values.

Top module: `xchg_bus_exchanger`

## Requirements
- R1: While `pass_a_to_b1` (or `pass_a_to_b2`) is high and that B port's enable is low, `b1_out` (or `b2_out`) equals `a_in` in the same cycle.
- R2: When an A-to-B open input is low, that B port's output holds the `a_in` value sampled at the last rising edge at which the open input was high, whatever `a_in` does afterwards, until the input is raised again.
- R3: The B1-to-A and B2-to-A paths behave the same way toward A: transparent from `b1_in` / `b2_in` while open, holding the last sampled value while closed.
- R4: With `route_b1` high, `a_out` shows the B1-to-A path; with it low, `a_out` shows the B2-to-A path. Switching `route_b1` while both return paths are closed swaps between the two held values at once.
- R5: The four paths are independent: opening, closing or loading one path leaves each other port's output unchanged.
- R6: Each enable (`a_oe_n`, `b1_oe_n`, `b2_oe_n`) is active low. When it is high, that port's drive flag is 0 and its output vector reads all zeros. When it is low, the drive flag is 1, and a held value reappears unchanged once the enable is lowered again.
- R7: A synchronous reset (`rst` high at a rising edge) clears all four held values to zero, so that after reset, with all paths closed and enables low, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the path inputs |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Data arriving on port A |
| b1_in | input | W | Data arriving on port B1 |
| b2_in | input | W | Data arriving on port B2 |
| pass_a_to_b1 | input | 1 | Open input of the A-to-B1 path |
| pass_a_to_b2 | input | 1 | Open input of the A-to-B2 path |
| pass_b1_to_a | input | 1 | Open input of the B1-to-A path |
| pass_b2_to_a | input | 1 | Open input of the B2-to-A path |
| route_b1 | input | 1 | 1 selects the B1 return path for A, 0 the B2 path |
| a_oe_n | input | 1 | Active-low output enable of port A |
| b1_oe_n | input | 1 | Active-low output enable of port B1 |
| b2_oe_n | input | 1 | Active-low output enable of port B2 |
| a_out | output | W | Data driven onto port A |
| a_drive | output | 1 | Port A pad drive flag |
| b1_out | output | W | Data driven onto port B1 |
| b1_drive | output | 1 | Port B1 pad drive flag |
| b2_out | output | W | Data driven onto port B2 |
| b2_drive | output | 1 | Port B2 pad drive flag |

## Verification
On every cycle the assertions check four things. A closed A-to-B path keeps its port output steady. The value shown right after a path closes is the input from the edge before. An open, selected return path shows its B input on A. A disabled port neither drives nor shows data. Only the directed scenarios can show the rest: independence of one path from another, the swap between two held values when the route select changes with both return paths closed, recovery of a held value after its enable returns, and the reset clearing.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  localparam int NUM_PATHS = 4;
  localparam int PATH_A_B1 = 0;
  localparam int PATH_A_B2 = 1;
  localparam int PATH_B1_A = 2;
  localparam int PATH_B2_A = 3;
endpackage

// File: rtl/xchg_hold_path.sv
module xchg_hold_path #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         open_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)         held_q <= '0;
    else if (open_i) held_q <= d_i;
  end

  // transparent while open, last sampled value while closed
  assign q_o = open_i ? d_i : held_q;
endmodule

// File: rtl/xchg_port_drv.sv
module xchg_port_drv #(
  parameter int W = 12
) (
  input  logic         oe_n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] out_o,
  output logic         drive_o
);
  assign drive_o = ~oe_n_i;
  assign out_o   = oe_n_i ? '0 : d_i;
endmodule

// File: rtl/xchg_bus_exchanger.sv
module xchg_bus_exchanger
  import xchg_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  input  logic         pass_a_to_b1,
  input  logic         pass_a_to_b2,
  input  logic         pass_b1_to_a,
  input  logic         pass_b2_to_a,
  input  logic         route_b1,
  input  logic         a_oe_n,
  input  logic         b1_oe_n,
  input  logic         b2_oe_n,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  output logic [W-1:0] b1_out,
  output logic         b1_drive,
  output logic [W-1:0] b2_out,
  output logic         b2_drive
);
  logic [W-1:0]         path_d [NUM_PATHS];
  logic [W-1:0]         path_q [NUM_PATHS];
  logic [NUM_PATHS-1:0] path_open;
  logic [W-1:0]         return_sel;

  assign path_d[PATH_A_B1] = a_in;
  assign path_d[PATH_A_B2] = a_in;
  assign path_d[PATH_B1_A] = b1_in;
  assign path_d[PATH_B2_A] = b2_in;

  assign path_open[PATH_A_B1] = pass_a_to_b1;
  assign path_open[PATH_A_B2] = pass_a_to_b2;
  assign path_open[PATH_B1_A] = pass_b1_to_a;
  assign path_open[PATH_B2_A] = pass_b2_to_a;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    xchg_hold_path #(.W(W)) u_path (
      .clk    (clk),
      .rst    (rst),
      .open_i (path_open[p]),
      .d_i    (path_d[p]),
      .q_o    (path_q[p])
    );
  end

  // return multiplexer toward the processor side
  always_comb begin
    if (route_b1) return_sel = path_q[PATH_B1_A];
    else          return_sel = path_q[PATH_B2_A];
  end

  xchg_port_drv #(.W(W)) u_drv_a (
    .oe_n_i (a_oe_n), .d_i (return_sel),
    .out_o  (a_out),  .drive_o (a_drive)
  );
  xchg_port_drv #(.W(W)) u_drv_b1 (
    .oe_n_i (b1_oe_n), .d_i (path_q[PATH_A_B1]),
    .out_o  (b1_out),  .drive_o (b1_drive)
  );
  xchg_port_drv #(.W(W)) u_drv_b2 (
    .oe_n_i (b2_oe_n), .d_i (path_q[PATH_A_B2]),
    .out_o  (b2_out),  .drive_o (b2_drive)
  );
endmodule

// File: rtl/xchg_checker.sv
module xchg_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b1_in,
  input logic [W-1:0] b2_in,
  input logic         pass_a_to_b1,
  input logic         pass_a_to_b2,
  input logic         pass_b1_to_a,
  input logic         pass_b2_to_a,
  input logic         route_b1,
  input logic         a_oe_n,
  input logic         b1_oe_n,
  input logic         b2_oe_n,
  input logic [W-1:0] a_out,
  input logic         a_drive,
  input logic [W-1:0] b1_out,
  input logic         b1_drive,
  input logic [W-1:0] b2_out,
  input logic         b2_drive
);
  assert_hold_b1_R2: assert property (@(posedge clk) disable iff (rst)
    (!pass_a_to_b1 && $past(!pass_a_to_b1) && !b1_oe_n && $past(!b1_oe_n) && !$past(rst))
      |-> (b1_out == $past(b1_out)));

  assert_capture_b2_R2: assert property (@(posedge clk) disable iff (rst)
    (!pass_a_to_b2 && $past(pass_a_to_b2) && !b2_oe_n && !$past(rst))
      |-> (b2_out == $past(a_in)));

  assert_route_b1_R4: assert property (@(posedge clk) disable iff (rst)
    (route_b1 && pass_b1_to_a && !a_oe_n) |-> (a_out == b1_in));

  assert_route_b2_R4: assert property (@(posedge clk) disable iff (rst)
    (!route_b1 && pass_b2_to_a && !a_oe_n) |-> (a_out == b2_in));

  assert_b1_off_R6: assert property (@(posedge clk) disable iff (rst)
    b1_oe_n |-> (!b1_drive && b1_out == '0));

  assert_a_off_R6: assert property (@(posedge clk) disable iff (rst)
    a_oe_n |-> (!a_drive && a_out == '0));
endmodule

bind xchg_bus_exchanger xchg_checker #(.W(W)) u_xchg_checker (.*);

// File: tb/test_xchg_bus_exchanger.sv
module test_xchg_bus_exchanger;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic         pass_a_to_b1 = 0, pass_a_to_b2 = 0, pass_b1_to_a = 0, pass_b2_to_a = 0;
  logic         route_b1 = 0, a_oe_n = 0, b1_oe_n = 0, b2_oe_n = 0;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic         a_drive, b1_drive, b2_drive;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  xchg_bus_exchanger #(.W(W)) i_xchg_bus_exchanger (.*);

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    b1_in = 12'h5A5; b2_in = 12'h3C3; a_in = 12'hF0F;
    repeat (3) @(posedge clk);
    settle(); rst = 0; #1;
    check("R7 b1_out after reset", b1_out, '0);
    check("R7 b2_out after reset", b2_out, '0);
    check("R7 a_out after reset",  a_out,  '0);
    check("R6 drive flags on", {9'd0, a_drive, b1_drive, b2_drive}, 12'd7);
  endtask

  task automatic t_forward();
    settle(); pass_a_to_b1 = 1; a_in = 12'hA5C; #1;
    check("R1 b1 transparent", b1_out, 12'hA5C);
    check("R5 b2 untouched",   b2_out, '0);
    a_in = 12'h123; #1;
    check("R1 b1 follows a_in", b1_out, 12'h123);
    settle(); pass_a_to_b1 = 0; a_in = 12'hFFF; #1;
    check("R2 b1 holds after close", b1_out, 12'h123);
    repeat (3) settle();
    a_in = 12'h0F0; #1;
    check("R2 b1 still held", b1_out, 12'h123);
  endtask

  task automatic t_independent();
    settle(); pass_a_to_b2 = 1; a_in = 12'h3C3; #1;
    check("R1 b2 transparent", b2_out, 12'h3C3);
    check("R5 b1 unaffected by b2 load", b1_out, 12'h123);
    settle(); pass_a_to_b2 = 0; a_in = 12'h000; #1;
    check("R2 b2 holds after close", b2_out, 12'h3C3);
    check("R5 b1 unchanged", b1_out, 12'h123);
  endtask

  task automatic t_return();
    settle(); route_b1 = 1; pass_b1_to_a = 1; b1_in = 12'h111; #1;
    check("R3 b1 to a transparent", a_out, 12'h111);
    settle(); pass_b1_to_a = 0; b1_in = 12'h222; #1;
    check("R3 a holds b1 value", a_out, 12'h111);
    settle(); route_b1 = 0; pass_b2_to_a = 1; b2_in = 12'h777; #1;
    check("R4 route b2 open", a_out, 12'h777);
    settle(); pass_b2_to_a = 0; b2_in = 12'h000; #1;
    check("R3 a holds b2 value", a_out, 12'h777);
    settle(); route_b1 = 1; #1;
    check("R4 swap to held b1", a_out, 12'h111);
    settle(); route_b1 = 0; #1;
    check("R4 swap to held b2", a_out, 12'h777);
    check("R5 b ports unchanged by return", b2_out, 12'h3C3);
  endtask

  task automatic t_enables();
    settle(); a_oe_n = 1; #1;
    check("R6 a_out off", a_out, '0);
    check("R6 a_drive off", {11'd0, a_drive}, 12'd0);
    settle(); b1_oe_n = 1; #1;
    check("R6 b1_out off", b1_out, '0);
    check("R6 b1_drive off", {11'd0, b1_drive}, 12'd0);
    check("R6 b2 still driven", b2_out, 12'h3C3);
    settle(); b1_oe_n = 0; a_oe_n = 0; #1;
    check("R6 b1 held value back", b1_out, 12'h123);
    check("R6 a held value back", a_out, 12'h777);
  endtask

  task automatic t_reset_again();
    settle(); rst = 1;
    settle(); rst = 0; #1;
    check("R7 b1 cleared", b1_out, '0);
    check("R7 b2 cleared", b2_out, '0);
    check("R7 a cleared (b2 path)", a_out, '0);
    settle(); route_b1 = 1; #1;
    check("R7 a cleared (b1 path)", a_out, '0);
  endtask

  initial begin
    t_reset();
    t_forward();
    t_independent();
    t_return();
    t_enables();
    t_reset_again();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule